// File: doc/BRIEF.md
# Windowed-MSB Watchdog Reset Generator

This block supervises the software of a small 8-bit microcontroller. A fixed prescaler divides the machine clock, and each prescaler wrap steps a 7-bit down-counter by one. Software reaches a one-byte control register and a one-byte status register over a simple register bus. The control register holds the counter value and an activate bit. Any write to the control register reloads the counter and restarts the prescaler. This write is the refresh.

Once activated, the block starts an active-low reset pulse of fixed length in two cases. The first is when the counter's top bit clears, which is the step from 40h to 3Fh. The second is when the processor signals HALT. A sticky status flag records that a watchdog reset happened, so boot code can tell it apart from power-on and clock-supervisor resets. Software clears that flag by writing zero, and a power-on reset also clears it. A watchdog reset leaves it set. The usable timeout is set by the six low bits loaded with bit 6 set, which gives 64 steps of PRESCALE machine cycles each.

Top module: `wdg_supervisor`

## Requirements
- R1: After `rst_i` or `por_i`, the control register reads 7Fh (activate bit 7 clear, counter 7Fh) and `wdg_rst_n_o` is high. After `por_i`, the status register reads 00h.
- R2: A control write at clock edge W loads counter bits 6:0 from `bus_wdata_i[6:0]` and restarts the prescaler. The counter then drops by one (modulo 128) at edges W+PRESCALE, W+2·PRESCALE, and so on.
- R3: With the watchdog active, the edge at which the counter steps from 40h to 3Fh drives `wdg_rst_n_o` low for exactly PULSE_LEN clock cycles, starting with that edge.
- R4: With the watchdog inactive, the counter keeps counting and wraps, and `wdg_rst_n_o` stays high.
- R5: Writing 1 to control bit 7 activates the watchdog. Writing 0 to bit 7 leaves it set. Only `rst_i` or `por_i` clears it.
- R6: `halt_i` high at an edge while the watchdog is active starts the reset pulse at that edge. While the watchdog is inactive, `halt_i` has no effect.
- R7: Status bit 0 is set at the edge a watchdog reset pulse starts. A status write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. `rst_i` leaves it unchanged and `por_i` clears it. A pulse start wins over a clearing write at the same edge.
- R8: A control write at the same edge where the 40h-to-3Fh step would occur takes precedence, and no reset pulse starts.
- R9: A trigger that arrives while the pulse is low neither extends nor restarts the pulse.
- R10: `bus_rdata_o` is registered. One edge after `bus_addr_i` is presented, it returns {activate, counter} for address 0 and {7'b0, flag} for address 1. It reads 00h during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Machine clock |
| rst_i | input | 1 | Synchronous active-high system reset |
| por_i | input | 1 | Synchronous active-high power-on reset; also clears the status flag |
| halt_i | input | 1 | HALT request from the processor |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 control, 1 status |
| bus_wdata_i | input | CNT_W+1 | Write data |
| bus_rdata_o | output | CNT_W+1 | Registered read data |
| wdg_rst_n_o | output | 1 | Active-low watchdog reset pulse |

## Verification
The hardest situation to reach is a refresh that lands on exactly the edge where the prescaler wraps and the counter holds 40h. Hitting it needs a cycle-exact count from the last control write. The bench loads 40h with the watchdog active, counts PRESCALE−1 edges, and issues the refresh on the wrap edge itself. A behavioural model checks every clock that no pulse starts there. Retriggers during a live pulse are reached by issuing HALT twice inside one pulse window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic REG_CTRL = 1'b0;
  localparam logic REG_STAT = 1'b1;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRESCALE = 12288
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick_o = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) pre_q <= '0;
    else if (tick_o)        pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    pre_q <= PRE_LAST); // R2
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             wr_ctrl_i,
  input  logic [CNT_W:0]   wdata_i,
  output logic             act_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             roll_o
);
  localparam logic [CNT_W-1:0] MSB_ONLY = CNT_W'(1) << (CNT_W - 1);

  // step from MSB_ONLY to MSB_ONLY-1 clears the top bit; a refresh suppresses it
  assign roll_o = tick_i && (cnt_o == MSB_ONLY) && !wr_ctrl_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      act_o <= 1'b0;
      cnt_o <= '1;
    end else if (wr_ctrl_i) begin
      act_o <= act_o | wdata_i[CNT_W];
      cnt_o <= wdata_i[CNT_W-1:0];
    end else if (tick_i) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  AST_ACT_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    act_o |=> act_o); // R5
  AST_WRITE_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_ctrl_i |=> (cnt_o == $past(wdata_i[CNT_W-1:0]))); // R2
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int PULSE_LEN = 62
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  output logic rst_n_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN - 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rst_n_o <= 1'b1;
      left_q  <= '0;
    end else if (trig_i && rst_n_o) begin
      rst_n_o <= 1'b0;
      left_q  <= LOAD;
    end else if (left_q != '0) begin
      left_q  <= left_q - 1'b1;
    end else begin
      rst_n_o <= 1'b1;
    end
  end

  // observation counter for the pulse-length check
  logic [PW:0] low_run_q;
  always_ff @(posedge clk_i) begin
    if (rst_i || rst_n_o) low_run_q <= '0;
    else                  low_run_q <= low_run_q + 1'b1;
  end

  AST_TRIG_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (trig_i && rst_n_o) |=> !rst_n_o); // R3
  AST_PULSE_MAX_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    low_run_q <= (PW+1)'(PULSE_LEN)); // R9
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
  parameter int PRESCALE  = 12288,
  parameter int PULSE_LEN = 62,
  parameter int CNT_W     = 7
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           por_i,
  input  logic           halt_i,
  input  logic           bus_wr_i,
  input  logic           bus_addr_i,
  input  logic [CNT_W:0] bus_wdata_i,
  output logic [CNT_W:0] bus_rdata_o,
  output logic           wdg_rst_n_o
);
  import wdg_pkg::*;

  logic             sys_rst, tick, act, roll, trig, flag_q;
  logic             wr_ctrl, wr_stat;
  logic [CNT_W-1:0] cnt;

  assign sys_rst = rst_i | por_i;
  assign wr_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);
  assign wr_stat = bus_wr_i && (bus_addr_i == REG_STAT);
  assign trig    = !sys_rst && act && (roll || halt_i);

  wdg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_i(sys_rst), .restart_i(wr_ctrl), .tick_o(tick));

  wdg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_i(sys_rst), .tick_i(tick), .wr_ctrl_i(wr_ctrl),
    .wdata_i(bus_wdata_i), .act_o(act), .cnt_o(cnt), .roll_o(roll));

  wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i(clk_i), .rst_i(sys_rst), .trig_i(trig), .rst_n_o(wdg_rst_n_o));

  always_ff @(posedge clk_i) begin
    if (por_i)                        flag_q <= 1'b0;
    else if (trig)                    flag_q <= 1'b1;
    else if (wr_stat && !bus_wdata_i[0]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (sys_rst)                      bus_rdata_o <= '0;
    else if (bus_addr_i == REG_CTRL)  bus_rdata_o <= {act, cnt};
    else                              bus_rdata_o <= {{CNT_W{1'b0}}, flag_q};
  end

  AST_NO_RST_INACTIVE: assert property (@(posedge clk_i) disable iff (sys_rst)
    (!act && wdg_rst_n_o) |=> wdg_rst_n_o); // R4
  AST_HALT_FIRES: assert property (@(posedge clk_i) disable iff (sys_rst)
    (act && halt_i && wdg_rst_n_o) |=> !wdg_rst_n_o); // R6
  AST_FLAG_ON_RESET: assert property (@(posedge clk_i) disable iff (sys_rst)
    $fell(wdg_rst_n_o) |-> flag_q); // R7
endmodule

// File: tb/tb_wdg_supervisor.sv
module tb_wdg_supervisor;
  localparam int P = 16;
  localparam int L = 5;

  logic clk = 1'b0;
  logic rst = 1'b1, por = 1'b1, halt = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rst_n;

  int checks = 0, failures = 0, lowcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdg_supervisor #(.PRESCALE(P), .PULSE_LEN(L), .CNT_W(7)) dut (
    .clk_i(clk), .rst_i(rst), .por_i(por), .halt_i(halt), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wdg_rst_n_o(rst_n));

  // behavioural reference model
  int m_act = 0, m_cnt = 127, m_pre = 0, m_low = 0, m_flag = 0, m_rdata = 0;
  always @(posedge clk) begin
    int trig;
    if (rst || por) begin
      m_act = 0; m_cnt = 127; m_pre = 0; m_low = 0; m_rdata = 0;
      if (por) m_flag = 0;
    end else begin
      m_rdata = (addr == 1'b0) ? (m_act * 128 + m_cnt) : m_flag;
      trig = (m_act != 0) && (halt || (m_pre == P-1 && m_cnt == 64 && !(wr && addr == 1'b0)));
      if (trig && m_low == 0) m_low = L;
      else if (m_low > 0) m_low = m_low - 1;
      if (trig) m_flag = 1;
      else if (wr && addr == 1'b1 && wdata[0] == 1'b0) m_flag = 0;
      if (wr && addr == 1'b0) begin
        m_cnt = wdata[6:0]; m_pre = 0;
        if (wdata[7]) m_act = 1;
      end else if (m_pre == P-1) begin
        m_pre = 0; m_cnt = (m_cnt + 127) % 128;
      end else m_pre = m_pre + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) lowcnt++;
      check(rst_n == (m_low == 0), "R3 model reset output", rst_n, m_low == 0);
      check(rdata == m_rdata[7:0], "R10 model read data", rdata, m_rdata);
    end
  end

  task automatic do_write(input logic a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask
  task automatic do_read(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask
  task automatic do_halt();
    @(negedge clk); halt = 1'b1;
    @(negedge clk); halt = 1'b0;
  endtask
  task automatic do_rst(input bit power);
    @(negedge clk); rst = 1'b1; por = power;
    repeat (2) @(negedge clk);
    rst = 1'b0; por = 1'b0;
  endtask
  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout, all requirements");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;
    // R1 reset state
    check(rst_n == 1'b1, "R1 output high", rst_n, 1);
    do_read(1'b0, v); check(v == 8'h7F, "R1 control", v, 8'h7F);
    do_read(1'b1, v); check(v == 8'h00, "R1 status", v, 0);

    // R4 inactive run through the 40h->3Fh step
    lowcnt = 0;
    do_write(1'b0, 8'h41);
    repeat (40) @(negedge clk);
    check(lowcnt == 0, "R4 no pulse when inactive", lowcnt, 0);
    do_read(1'b0, v); check(v == 8'h3F, "R4 counter kept running", v, 8'h3F);

    // R2 reload and step
    do_write(1'b0, 8'h50);
    do_read(1'b0, v); check(v == 8'h50, "R2 reload", v, 8'h50);
    repeat (P) @(negedge clk);
    do_read(1'b0, v); check(v == 8'h4F, "R2 one step", v, 8'h4F);

    // R6 halt while inactive
    lowcnt = 0; do_halt(); repeat (3) @(negedge clk);
    check(lowcnt == 0, "R6 halt ignored inactive", lowcnt, 0);

    // R3 rollover pulse
    lowcnt = 0;
    do_write(1'b0, 8'hC1);
    repeat (40) @(negedge clk);
    check(lowcnt == L, "R3 pulse length", lowcnt, L);
    do_read(1'b1, v); check(v == 8'h01, "R7 flag set", v, 1);

    // R5 sticky activate
    do_write(1'b0, 8'h7F);
    do_read(1'b0, v); check(v[7] == 1'b1, "R5 activate sticky", v[7], 1);

    // R7 clear rules
    do_write(1'b1, 8'h01);
    do_read(1'b1, v); check(v == 8'h01, "R7 write one keeps", v, 1);
    do_write(1'b1, 8'h00);
    do_read(1'b1, v); check(v == 8'h00, "R7 write zero clears", v, 0);

    // R6 + R9 halt while active, retrigger in pulse
    do_write(1'b0, 8'hFF);
    lowcnt = 0;
    do_halt(); @(negedge clk); do_halt();
    repeat (10) @(negedge clk);
    check(lowcnt == L, "R9 no extension", lowcnt, L);
    do_read(1'b1, v); check(v == 8'h01, "R6 halt sets flag", v, 1);

    // R7 system reset keeps flag, R5 clears activate
    do_rst(1'b0);
    do_read(1'b1, v); check(v == 8'h01, "R7 rst keeps flag", v, 1);
    do_read(1'b0, v); check(v == 8'h7F, "R5 rst clears activate", v, 8'h7F);
    do_rst(1'b1);
    do_read(1'b1, v); check(v == 8'h00, "R7 por clears flag", v, 0);

    // R8 refresh on the rollover edge
    do_write(1'b0, 8'hC0);
    repeat (14) @(negedge clk);
    lowcnt = 0;
    do_write(1'b0, 8'hFF);
    repeat (10) @(negedge clk);
    check(lowcnt == 0, "R8 refresh wins", lowcnt, 0);
    do_read(1'b1, v); check(v == 8'h00, "R8 flag untouched", v, 0);

    finish_run();
  end
endmodule